// File: doc/BRIEF.md
# Masked-Count Shift and Rotate Unit

This block is the shift and rotate slice of a processor execution stage. Each operation takes a 32-bit operand, an 8-bit requested count, an instruction byte in register form, and the incoming arithmetic flags. It returns the shifted or rotated operand and the updated flags. The instruction byte selects the operation through its three-bit operation field.

Only the low five bits of the requested count are used. A request to shift by 32 therefore does nothing, and shifting 1 left by 32 gives 1, not 0. Software that needs a full clear has to handle counts of 32 and above itself.

Results and flags are registered. They appear one clock after `valid_i`, with `valid_o` marking that cycle. Between operations the last result stays on the outputs.

Top module: `shift_rotate_unit`

## Requirements
- R1: The effective count is `count_i[4:0]`, so a requested count of 32 acts as 0. Operand 1 shifted left by 32 returns 1.
- R2: The operation field is `instr_i[5:3]`, decoded as 000 rotate left, 001 rotate right, 100 logical left shift, 101 logical right shift and 111 arithmetic right shift. Codes 010, 011 and 110 return the operand unchanged and the incoming flags unchanged.
- R3: A logical left shift fills vacated low bits with zeros. For effective count n, carry is the last bit shifted out, `operand[32-n]`.
- R4: A logical right shift fills vacated high bits with zeros, and carry is `operand[n-1]`.
- R5: An arithmetic right shift fills vacated high bits with copies of the operand's sign bit, and carry is `operand[n-1]`.
- R6: Rotates re-insert the bits that leave one end at the other end. After a rotate left, carry equals result bit 0. After a rotate right, carry equals result bit 31.
- R7: With an effective count of zero, the result equals the operand and all four output flags equal `flags_i`.
- R8: For a nonzero count, shift operations set the zero flag when the result is 0 and copy result bit 31 into the sign flag. Rotates pass the zero and sign flags through from `flags_i`.
- R9: Overflow is computed only at effective count 1:
  - logical left shift and rotate left: result bit 31 XOR new carry;
  - rotate right: result bit 31 XOR result bit 30;
  - logical right shift: the original operand bit 31;
  - arithmetic right shift: 0.
  At any other nonzero count, overflow passes through from `flags_i`.
- R10: Result and flags are registered one cycle after `valid_i` is high, and `valid_o` pulses in that cycle. With `valid_i` low, `valid_o` is low and the result and flags hold.
- R11: Reset clears `valid_o`, the result and the flags to zero.
- R12: Flag bit positions in `flags_i` and `flags_o` are: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| instr_i | input | 8 | Register-form instruction byte; bits 5:3 select the operation |
| operand_i | input | 32 | Destination operand |
| count_i | input | 8 | Requested count; only the low five bits are used |
| flags_i | input | 4 | Incoming flags {sign, zero, overflow, carry} |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 32 | Shifted or rotated result |
| flags_o | output | 4 | Updated flags {sign, zero, overflow, carry} |

## Verification
The assertions assume that `instr_i`, `operand_i`, `count_i` and `flags_i` are stable and known whenever `valid_i` is high. They also assume that `valid_i` is low while reset is held.

The bench changes inputs only on the falling clock edge, holds `valid_i` high for exactly one cycle per operation, and keeps `valid_i` low during reset. It also reaches both of the corner cases above:
- requested counts at and above 32, so that the effective count wraps to small values or zero;
- the three unused operation codes.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_ROL = 3'b000,
    OP_ROR = 3'b001,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101,
    OP_SAR = 3'b111
  } sru_op_e;

  typedef struct packed {
    logic sf;
    logic zf;
    logic of;
    logic cf;
  } sru_flags_t;
endpackage

// File: rtl/sru_decode.sv
module sru_decode
  import sru_pkg::*;
(
  input  logic [7:0] instr_i,
  output sru_op_e    op_o,
  output logic       legal_o
);
  logic [2:0] field;
  assign field = instr_i[5:3];

  always_comb begin
    legal_o = 1'b1;
    op_o    = OP_ROL;
    unique case (field)
      3'b000:  op_o = OP_ROL;
      3'b001:  op_o = OP_ROR;
      3'b100:  op_o = OP_SHL;
      3'b101:  op_o = OP_SHR;
      3'b111:  op_o = OP_SAR;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
  import sru_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  sru_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [CW-1:0]  n_i,
  output logic [W-1:0]   res_o,
  output logic           cf_o
);
  logic [W:0]          shl_x, shr_x, sar_x;
  logic signed [W:0]   sar_in;
  logic [2*W-1:0]      rol_x, ror_x;

  // extra bit catches the last bit shifted out
  assign shl_x  = {1'b0, a_i} << n_i;
  assign shr_x  = {a_i, 1'b0} >> n_i;
  assign sar_in = {a_i, 1'b0};
  assign sar_x  = sar_in >>> n_i;
  assign rol_x  = {a_i, a_i} << n_i;
  assign ror_x  = {a_i, a_i} >> n_i;

  always_comb begin
    res_o = a_i;
    cf_o  = 1'b0;
    unique case (op_i)
      OP_SHL: begin res_o = shl_x[W-1:0];   cf_o = shl_x[W]; end
      OP_SHR: begin res_o = shr_x[W:1];     cf_o = shr_x[0]; end
      OP_SAR: begin res_o = sar_x[W:1];     cf_o = sar_x[0]; end
      OP_ROL: begin res_o = rol_x[2*W-1:W]; cf_o = rol_x[W]; end
      OP_ROR: begin res_o = ror_x[W-1:0];   cf_o = ror_x[W-1]; end
      default: begin res_o = a_i;           cf_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/sru_flags.sv
module sru_flags
  import sru_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  sru_op_e       op_i,
  input  logic          legal_i,
  input  logic [CW-1:0] n_i,
  input  logic          a_msb_i,
  input  logic [W-1:0]  res_i,
  input  logic          cf_i,
  input  sru_flags_t    flags_i,
  output sru_flags_t    flags_o
);
  logic is_rot, one;
  assign is_rot = (op_i == OP_ROL) || (op_i == OP_ROR);
  assign one    = (n_i == CW'(1));

  always_comb begin
    flags_o = flags_i;
    if (legal_i && (n_i != '0)) begin
      flags_o.cf = cf_i;
      if (!is_rot) begin
        flags_o.zf = (res_i == '0);
        flags_o.sf = res_i[W-1];
      end
      if (one) begin
        unique case (op_i)
          OP_SHL, OP_ROL: flags_o.of = res_i[W-1] ^ cf_i;
          OP_ROR:         flags_o.of = res_i[W-1] ^ res_i[W-2];
          OP_SHR:         flags_o.of = a_msb_i;
          OP_SAR:         flags_o.of = 1'b0;
          default:        flags_o.of = flags_i.of;
        endcase
      end
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter int unsigned CIN_W = 8,
  localparam int unsigned CW  = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       instr_i,
  input  logic [W-1:0]     operand_i,
  input  logic [CIN_W-1:0] count_i,
  input  logic [3:0]       flags_i,
  output logic             valid_o,
  output logic [W-1:0]     result_o,
  output logic [3:0]       flags_o
);
  sru_op_e       op;
  logic          legal;
  logic [CW-1:0] n;
  logic [W-1:0]  dp_res, res_d;
  logic          dp_cf;
  sru_flags_t    flg_d;

  assign n = count_i[CW-1:0];  // count masked to log2(W) bits

  sru_decode u_dec (.instr_i(instr_i), .op_o(op), .legal_o(legal));

  sru_datapath #(.W(W), .CW(CW)) u_dp (
    .op_i(op), .a_i(operand_i), .n_i(n), .res_o(dp_res), .cf_o(dp_cf)
  );

  sru_flags #(.W(W), .CW(CW)) u_flg (
    .op_i(op), .legal_i(legal), .n_i(n), .a_msb_i(operand_i[W-1]),
    .res_i(dp_res), .cf_i(dp_cf), .flags_i(sru_flags_t'(flags_i)),
    .flags_o(flg_d)
  );

  assign res_d = legal ? dp_res : operand_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flg_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o)); // R10

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && count_i[CW-1:0] == '0 |=>
      result_o == $past(operand_i) && flags_o == $past(flags_i)); // R7

  AST_SAR_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[5:3] == 3'b111 && count_i[CW-1:0] == CW'(1) |=>
      !flags_o[1]); // R9

  AST_SHL_CARRY_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[5:3] == 3'b100 && count_i[CW-1:0] == CW'(1) |=>
      flags_o[0] == $past(operand_i[W-1])); // R3

  AST_ROT_KEEPS_ZS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[5:4] == 2'b00 |=>
      flags_o[3:2] == $past(flags_i[3:2])); // R8

  AST_ROL_CARRY_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[5:3] == 3'b000 && count_i[CW-1:0] != '0 |=>
      flags_o[0] == result_o[0]); // R6
endmodule

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  instr_i = '0;
  logic [31:0] operand_i = '0;
  logic [7:0]  count_i = '0;
  logic [3:0]  flags_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  shift_rotate_unit i_shift_rotate_unit (
    .clk_i, .rst_ni, .valid_i, .instr_i, .operand_i, .count_i, .flags_i,
    .valid_o, .result_o, .flags_o
  );

  // {instr, operand, count, flags_in, exp_result, exp_flags}; flags {sf,zf,of,cf}
  localparam int NV = 15;
  localparam logic [87:0] VEC [NV] = '{
    {8'hE3, 32'h0000_0001, 8'd32, 4'b0000, 32'h0000_0001, 4'b0000}, // R1 R7
    {8'hE3, 32'hC000_0001, 8'd1,  4'b0000, 32'h8000_0002, 4'b1001}, // R3 R9
    {8'hE3, 32'h8000_0000, 8'd1,  4'b0000, 32'h0000_0000, 4'b0111}, // R3 R8
    {8'hE3, 32'h0000_00F0, 8'd36, 4'b0010, 32'h0000_0F00, 4'b0010}, // R1 R9
    {8'hE3, 32'h0000_0001, 8'd31, 4'b0000, 32'h8000_0000, 4'b1000}, // R3
    {8'hEB, 32'h8000_0003, 8'd1,  4'b0000, 32'h4000_0001, 4'b0011}, // R4 R9
    {8'hEB, 32'h0000_00F0, 8'd5,  4'b0000, 32'h0000_0007, 4'b0001}, // R4
    {8'hFB, 32'h8000_0010, 8'd4,  4'b0000, 32'hF800_0001, 4'b1000}, // R5
    {8'hFB, 32'hFFFF_FFFF, 8'd1,  4'b0010, 32'hFFFF_FFFF, 4'b1001}, // R5 R9
    {8'hC3, 32'h8000_0001, 8'd1,  4'b1100, 32'h0000_0003, 4'b1111}, // R6 R8
    {8'hC3, 32'h1234_5678, 8'd8,  4'b0000, 32'h3456_7812, 4'b0000}, // R6
    {8'hCB, 32'h0000_0001, 8'd1,  4'b0000, 32'h8000_0000, 4'b0011}, // R6 R9
    {8'hCB, 32'h1234_5678, 8'd4,  4'b0100, 32'h8123_4567, 4'b0101}, // R6 R8
    {8'hD3, 32'hDEAD_BEEF, 8'd3,  4'b1010, 32'hDEAD_BEEF, 4'b1010}, // R2
    {8'hEB, 32'h0000_0005, 8'd64, 4'b0110, 32'h0000_0005, 4'b0110}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] ins, input logic [31:0] a,
                        input logic [7:0] c, input logic [3:0] f);
    @(negedge clk_i);
    instr_i = ins; operand_i = a; count_i = c; flags_i = f; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 valid", {31'd0, valid_o}, 32'd0);
    check("R11 result", result_o, 32'd0);
    check("R11 flags", {28'd0, flags_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][87:80], VEC[i][79:48], VEC[i][47:40], VEC[i][39:36]);
      check($sformatf("R10 valid vec%0d", i), {31'd0, valid_o}, 32'd1);
      check($sformatf("R1-R9 result vec%0d", i), result_o, VEC[i][35:4]);
      check($sformatf("R12 flags vec%0d", i), {28'd0, flags_o}, {28'd0, VEC[i][3:0]});
    end

    // R10: idle cycle, inputs change, outputs hold
    @(negedge clk_i);
    instr_i = 8'hE3; operand_i = 32'hFFFF_0000; count_i = 8'd3; flags_i = 4'b1111;
    @(negedge clk_i);
    check("R10 idle valid", {31'd0, valid_o}, 32'd0);
    check("R10 idle result", result_o, 32'h0000_0005);
    check("R10 idle flags", {28'd0, flags_o}, 32'h6);

    // R2: remaining unused codes 011 and 110
    run_op(8'hDB, 32'h0F0F_0F0F, 8'd2, 4'b0001);
    check("R2 code011 result", result_o, 32'h0F0F_0F0F);
    check("R2 code011 flags", {28'd0, flags_o}, 32'h1);
    run_op(8'hF3, 32'h0F0F_0F0F, 8'd2, 4'b1000);
    check("R2 code110 result", result_o, 32'h0F0F_0F0F);
    check("R2 code110 flags", {28'd0, flags_o}, 32'h8);

    // R11: reset after activity
    run_op(8'hE3, 32'h1, 8'd4, 4'b0000);
    check("R3 pre-reset result", result_o, 32'h10);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11 rerst result", result_o, 32'd0);
    check("R11 rerst flags", {28'd0, flags_o}, 32'd0);
    rst_ni = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule